// File: doc/BRIEF.md
# UART Interrupt Enable and Priority Logic

This block is the interrupt section of a 16550-style UART. It has a 4-bit enable register and takes five condition inputs: line status, received data ready, character timeout, transmitter holding register empty and modem status. It chooses the highest-priority condition that is both enabled and pending. It reports that choice as a 4-bit identification code and drives one active-high interrupt line.

A small register port reaches both registers. Address 0 is the enable register and can be read and written. Address 1 is the identification register and can only be read. A read access lasts for as long as `rd_en` is held with `addr` = 1.

During a read access of the identification register, the reported code and the interrupt line are held at the values they had when the access began. Conditions that arrive during the access are still recorded, and they appear once the access ends. The transmitter-empty condition is an internal flag. It is armed by events and cleared by the usual software actions.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A write at address 0 loads `wdata[3:0]` into the enable register. Bit 0 enables received data and character timeout, bit 1 enables transmitter empty, bit 2 enables line status and bit 3 enables modem status. A read at address 0 returns the four enable bits in `rdata[3:0]`, and `rdata[7:4]` always reads 0.
- R2: After reset the enable register reads 0x00, the identification register reads 0x01 and `irq` is low.
- R3: A condition whose enable bit is 0 never appears in the identification code and never raises `irq`. With all enable bits cleared, `irq` stays low whatever the inputs do.
- R4: The priority order, highest first, is: line status (code 0x6), receive data (code 0x4 for data ready, 0xC for character timeout), transmitter empty (code 0x2), modem status (code 0x0). When nothing is pending the code is 0x1. Bit 0 of the code is 0 exactly when an interrupt is pending.
- R5: Character timeout is gated by enable bit 0. When both data ready and character timeout are set, the code is 0xC.
- R6: While the identification register is being read, `rdata` and `irq` keep the values they had when the access started. Events that arrive during the access show up one clock edge after `rd_en` drops.
- R7: Writes to address 1 change neither register.
- R8: The transmitter-empty flag is set on a rising edge of `thr_empty`, or by a write that changes enable bit 1 from 0 to 1 while `thr_empty` is high. It is cleared by a `thr_write` pulse, or by a read access that begins while the reported code is 0x2.
- R9: Outside a read access, `irq` and the code follow level inputs on the next rising clock edge. `irq` is high exactly when code bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, held for the whole access |
| addr | input | 1 | 0 = enable register, 1 = identification register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| line_stat | input | 1 | Receiver line status condition |
| rx_ready | input | 1 | Received data ready condition |
| char_timeout | input | 1 | FIFO character timeout condition |
| thr_empty | input | 1 | Transmit holding register is empty (level) |
| thr_write | input | 1 | Pulse: transmit holding register written |
| modem_stat | input | 1 | Modem status condition |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach is an event that lands in the middle of a long identification read. The bench raises `rd_en` and lets one edge pass so that the code is frozen. It then asserts modem status and waits two more edges, and checks that both the code and `irq` are unchanged. Only after that does it drop `rd_en`. The transmitter-empty clear-on-read is reached in the same way: the flag is armed first, and then a single read is issued while the code is 0x2.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       line_stat,
  input  logic       rx_ready,
  input  logic       char_timeout,
  input  logic       thr_empty,
  input  logic       thr_write,
  input  logic       modem_stat,
  output logic       irq
);
  localparam logic [3:0] CODE_NONE = 4'h1;
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_DATA = 4'h4;
  localparam logic [3:0] CODE_TOUT = 4'hC;
  localparam logic [3:0] CODE_THRE = 4'h2;
  localparam logic [3:0] CODE_MDM  = 4'h0;

  logic [3:0] en_q;
  logic [3:0] code_q;
  logic [3:0] code_live;
  logic       irq_q;
  logic       acc_q;
  logic       empty_q;
  logic       thre_pend;

  wire acc      = rd_en & addr;
  wire acc_go   = acc & ~acc_q;
  wire en_wr    = wr_en & ~addr;
  wire thre_arm = (thr_empty & ~empty_q) |
                  (en_wr & wdata[1] & ~en_q[1] & thr_empty);

  logic unused_hi;
  assign unused_hi = ^wdata[7:4];

  always_comb begin
    if (en_q[2] && line_stat)         code_live = CODE_LINE;
    else if (en_q[0] && char_timeout) code_live = CODE_TOUT;
    else if (en_q[0] && rx_ready)     code_live = CODE_DATA;
    else if (en_q[1] && thre_pend)    code_live = CODE_THRE;
    else if (en_q[3] && modem_stat)   code_live = CODE_MDM;
    else                              code_live = CODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      code_q    <= CODE_NONE;
      irq_q     <= 1'b0;
      acc_q     <= 1'b0;
      empty_q   <= 1'b1;
      thre_pend <= 1'b0;
    end else begin
      acc_q   <= acc;
      empty_q <= thr_empty;
      if (en_wr) en_q <= wdata[3:0];
      if (!acc) begin
        code_q <= code_live;
        irq_q  <= ~code_live[0];
      end
      if (thr_write)                          thre_pend <= 1'b0;
      else if (thre_arm)                      thre_pend <= 1'b1;
      else if (acc_go && code_q == CODE_THRE) thre_pend <= 1'b0;
    end
  end

  assign rdata = addr ? {4'b0000, code_q} : {4'b0000, en_q};
  assign irq   = irq_q;

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 4'h0 && !acc) |=> !irq);

  p_line_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[2] && line_stat && !acc) |=> (code_q == CODE_LINE));

  p_frozen_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_q) |-> ($stable(code_q) && $stable(irq_q)));

  p_thr_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> !thre_pend);

  p_irq_tracks_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (irq == !code_q[0]));
endmodule

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic line_stat = 0, rx_ready = 0, char_timeout = 0;
  logic thr_empty = 0, thr_write = 0, modem_stat = 0;
  logic irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl uut (.*);

  // {enable[3:0], line, rx, tout, modem, expected code[3:0]}
  localparam logic [11:0] VEC [10] = '{
    {4'hF, 4'b1111, 4'h6}, {4'hF, 4'b0111, 4'hC}, {4'hF, 4'b0101, 4'h4},
    {4'hF, 4'b0001, 4'h0}, {4'hB, 4'b1111, 4'hC}, {4'h8, 4'b1110, 4'h1},
    {4'h8, 4'b1111, 4'h0}, {4'h0, 4'b1111, 4'h1}, {4'h1, 4'b0010, 4'hC},
    {4'hE, 4'b0010, 4'h1}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0; addr = 0;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    check("R2 irq", {7'b0, irq}, 8'h00);
    bus_rd(1'b1, v); check("R2 id", v, 8'h01);
    bus_rd(1'b0, v); check("R2 enable", v, 8'h00);

    // R1 reserved bits
    bus_wr(1'b0, 8'hFF); bus_rd(1'b0, v); check("R1 enable readback", v, 8'h0F);
    // R7 writes to identification register ignored
    modem_stat = 1; settle();
    bus_wr(1'b1, 8'h3C); settle();
    bus_rd(1'b1, v); check("R7 id unchanged", v, 8'h00);
    bus_rd(1'b0, v); check("R7 enable unchanged", v, 8'h0F);
    modem_stat = 0;

    // R3 R4 R5 R9 vector table
    for (int i = 0; i < 10; i++) begin
      bus_wr(1'b0, {4'h0, VEC[i][11:8]});
      {line_stat, rx_ready, char_timeout, modem_stat} = VEC[i][7:4];
      settle();
      check($sformatf("R4 R9 irq row %0d", i), {7'b0, irq}, {7'b0, ~VEC[i][0]});
      bus_rd(1'b1, v);
      check($sformatf("R3 R4 R5 code row %0d", i), v, {4'h0, VEC[i][3:0]});
    end
    {line_stat, rx_ready, char_timeout, modem_stat} = 4'b0;

    // R8 transmitter empty arming and clear on read
    bus_wr(1'b0, 8'h02);
    @(negedge clk); thr_empty = 1; settle(); settle();
    check("R8 armed irq", {7'b0, irq}, 8'h01);
    bus_rd(1'b1, v); check("R8 code thre", v, 8'h02);
    settle();
    check("R8 cleared by read irq", {7'b0, irq}, 8'h00);
    bus_rd(1'b1, v); check("R8 cleared by read code", v, 8'h01);
    // R8 re-arm by enable rise while empty
    bus_wr(1'b0, 8'h00); bus_wr(1'b0, 8'h02); settle();
    check("R8 rearm by enable", {7'b0, irq}, 8'h01);
    // R8 clear by holding register write
    @(negedge clk); thr_write = 1; @(negedge clk); thr_write = 0; thr_empty = 0;
    settle();
    check("R8 cleared by write", {7'b0, irq}, 8'h00);

    // R6 freeze during long read
    bus_wr(1'b0, 8'h0F); settle();
    @(negedge clk); rd_en = 1; addr = 1;
    @(negedge clk); modem_stat = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R6 frozen code", rdata, 8'h01);
    check("R6 frozen irq", {7'b0, irq}, 8'h00);
    rd_en = 0; addr = 0;
    @(posedge clk); @(negedge clk);
    check("R6 released irq", {7'b0, irq}, 8'h01);
    bus_rd(1'b1, v); check("R6 released code", v, 8'h00);

    // R3 all disabled silences irq
    line_stat = 1; rx_ready = 1; bus_wr(1'b0, 8'h00); settle();
    check("R3 all disabled", {7'b0, irq}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule